// File: doc/BRIEF.md
# Five-Stage In-Order ALU Pipeline with Switchable Execute Bypass

This block is a small in-order integer pipeline. It runs three-register ALU instructions (add, subtract, bitwise AND, bitwise XOR) held in a small local instruction memory. Every instruction passes through five stages: fetch, decode, operand fetch, execute and writeback. Each stage holds at most one instruction at a time.

The register file reads both sources of the instruction in operand fetch into two operand registers. Execute then forms the result into a single result register, which is also the bypass register. Writeback commits that result to the register file. A parameter picks one of two builds. In one, the result register feeds back to the execute inputs, so a dependent instruction directly behind its producer never waits. In the other, the interlock holds that instruction in operand fetch for exactly one cycle, until its value reaches the register file.

A program is loaded through the instruction-memory write port, normally while reset is held, and runs from address 0 once reset is released. Debug outputs show the PC, the contents of each stage, the operand and bypass registers, the register file, and the per-register busy flags.

Top module: `inorder_pipe5`

## Requirements
- R1: While reset (active-low, sampled at the clock edge) is low, the PC is 0 and every stage is empty (valid bit 0, no write-back). Register i is set to (i+1)*0x1111, and no busy flag is set. Reset leaves the instruction memory unchanged.
- R2: An instruction word is 12 bits: bit 11 valid, bits 10:9 operation, bits 8:6 destination, bits 5:3 first source, bits 2:0 second source. The operation codes are 00 add, 01 subtract (first minus second), 10 AND and 11 XOR. Results are 16 bits, and every register update matches sequential program order.
- R3: After reset is released, the instruction at address k is presented in writeback (write-back enable high, with its destination and result) after exactly k+4 rising edges. Each earlier stall cycle adds one edge to this count. Without a stall, the PC advances by one per edge and wraps at the memory depth.
- R4: When an instruction leaves operand fetch, the S1 and S2 outputs carry the current values of its first and second source registers.
- R5: An instruction two slots behind its producer reads the new value without stalling, because a register written in writeback is seen by operand fetch in the same cycle.
- R6: With the bypass off, an instruction that reads the destination of the instruction directly ahead of it is held for exactly one cycle. In that cycle the stall output is high, the PC, fetch and decode registers hold their values, and execute receives an empty slot. No other situation stalls.
- R7: With the bypass on, the pipeline never stalls. A dependent instruction directly behind its producer takes the result register's value in execute instead of its stale operand.
- R8: Busy flag r is high while an instruction writing register r sits in execute or writeback.
- R9: Two writes to the same register update it in program order, and a later reader sees the younger value.
- R10: A memory word with valid bit 0 passes through as an empty slot. It writes nothing and causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_we | input | 1 | Instruction memory write enable |
| imem_addr | input | IA_W (5) | Instruction memory write address |
| imem_wdata | input | 12 | Instruction word to store |
| dbg_pc | output | IA_W (5) | Current fetch address |
| dbg_stall | output | 1 | Interlock holding fetch, decode and operand fetch this cycle |
| dbg_fi_instr | output | 12 | Instruction in the fetch register |
| dbg_di_instr | output | 12 | Instruction in the decode register (in operand fetch) |
| dbg_fo_instr | output | 12 | Instruction in the operand register (in execute) |
| dbg_s1 | output | 16 | First source operand register |
| dbg_s2 | output | 16 | Second source operand register |
| dbg_by | output | 16 | Execute result / bypass register |
| dbg_wb_en | output | 1 | Instruction in writeback is valid |
| dbg_wb_rd | output | 3 | Destination of the instruction in writeback |
| dbg_regs | output | NREGS*16 | Register file, register i at bits i*16 upward |
| dbg_reg_busy | output | NREGS | Per-register pending-write flags |

## Verification
A wrong interlock decision shows up in the same cycle on the stall output. Within one edge the PC and execute slot follow it, and from then on every later writeback lands one cycle early or late, so the scoreboard's per-instruction cycle check exposes it. A stale or wrong bypass selection corrupts the value on the result register one edge after the instruction enters execute, and that value is compared against a sequential model at writeback. A corrupted register write or a write-after-write slip stays hidden until a later reader uses it or until the end-of-program register image is compared, so each program is made to re-read the registers it wrote.

// File: rtl/p5_pkg.sv
// Package: shared widths, instruction and result types, and the ALU function
// for the five-stage pipeline. Assumes at most 8 architectural registers.
package p5_pkg;
    localparam int DATA_W = 16;
    localparam int RA_W   = 3;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_AND = 2'b10,
        OP_XOR = 2'b11
    } op_e;

    typedef struct packed {
        logic            vld;
        op_e             op;
        logic [RA_W-1:0] rd;
        logic [RA_W-1:0] rs1;
        logic [RA_W-1:0] rs2;
    } instr_t;

    localparam int INSTR_W = $bits(instr_t);

    typedef struct packed {
        logic              vld;
        logic [RA_W-1:0]   rd;
        logic [DATA_W-1:0] data;
    } result_t;

    // Compute one ALU result.
    function automatic logic [DATA_W-1:0] alu(input op_e op,
                                              input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b);
        case (op)
            OP_ADD:  return a + b;
            OP_SUB:  return a - b;
            OP_AND:  return a & b;
            default: return a ^ b;
        endcase
    endfunction
endpackage

// File: rtl/p5_fetch.sv
// Fetch stage: local instruction memory, PC and fetch register.
// Assumes IMEM_DEPTH is a power of two so the PC wraps naturally.
// The memory is not reset; it is loaded through the write port.
module p5_fetch
    import p5_pkg::*;
#(
    parameter int IMEM_DEPTH = 32,
    localparam int IA_W = $clog2(IMEM_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall,
    input  logic               imem_we,
    input  logic [IA_W-1:0]    imem_addr,
    input  logic [INSTR_W-1:0] imem_wdata,
    output logic [IA_W-1:0]    pc,
    output instr_t             fi_q
);
    logic [INSTR_W-1:0] mem_q [IMEM_DEPTH];
    logic [IA_W-1:0]    pc_q;

    // Program load port.
    always_ff @(posedge clk) begin
        if (imem_we) begin
            mem_q[imem_addr] <= imem_wdata;
        end
    end

    // Fetch one word per cycle unless the interlock holds the front end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            fi_q <= '0;
        end else if (!stall) begin
            fi_q <= instr_t'(mem_q[pc_q]);
            pc_q <= pc_q + 1'b1;
        end
    end

    assign pc = pc_q;

    assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> pc_q == IA_W'($past(pc_q) + 1'b1));
endmodule

// File: rtl/p5_regfile.sv
// Register file: NREGS x DATA_W, one write port from writeback and two read
// ports for operand fetch. A read of the register being written returns the
// new value (write in the first half of the cycle). Reset loads (i+1)*0x1111.
module p5_regfile
    import p5_pkg::*;
#(
    parameter int NREGS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  result_t                 wr,
    input  logic [RA_W-1:0]         addr_a,
    input  logic [RA_W-1:0]         addr_b,
    output logic [DATA_W-1:0]       rd_a,
    output logic [DATA_W-1:0]       rd_b,
    output logic [NREGS*DATA_W-1:0] regs_flat
);
    logic [DATA_W-1:0] regs_q [NREGS];

    // Reset to the fixed pattern, then commit writeback results.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREGS; i++) begin
            if (!rst_n) begin
                regs_q[i] <= DATA_W'((i + 1) * 32'h1111);
            end else if (wr.vld && wr.rd == RA_W'(i)) begin
                regs_q[i] <= wr.data;
            end
        end
    end

    // Two read ports with write-first forwarding.
    always_comb begin
        rd_a = '0;
        rd_b = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (addr_a == RA_W'(i)) rd_a = regs_q[i];
            if (addr_b == RA_W'(i)) rd_b = regs_q[i];
        end
        if (wr.vld && wr.rd == addr_a) rd_a = wr.data;
        if (wr.vld && wr.rd == addr_b) rd_b = wr.data;
    end

    // Flatten the register image for the debug tap.
    always_comb begin
        for (int i = 0; i < NREGS; i++) begin
            regs_flat[i*DATA_W +: DATA_W] = regs_q[i];
        end
    end
endmodule

// File: rtl/p5_hazard.sv
// Interlock and bypass control. Compares the instruction in operand fetch
// with the one in execute, and the one in execute with the one in writeback.
// BYPASS_EN picks the variant: bypass select with no stall, or a one-cycle
// stall with no bypass.
module p5_hazard
    import p5_pkg::*;
#(
    parameter bit BYPASS_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            di_vld,
    input  logic [RA_W-1:0] di_rs1,
    input  logic [RA_W-1:0] di_rs2,
    input  logic            fo_vld,
    input  logic [RA_W-1:0] fo_rd,
    input  logic [RA_W-1:0] fo_rs1,
    input  logic [RA_W-1:0] fo_rs2,
    input  logic            ex_vld,
    input  logic [RA_W-1:0] ex_rd,
    output logic            stall,
    output logic            byp_a,
    output logic            byp_b
);
    logic dep;

    // Operand fetch reads the destination of the instruction in execute.
    assign dep = di_vld && fo_vld && (fo_rd == di_rs1 || fo_rd == di_rs2);

    if (BYPASS_EN) begin : g_bypass
        // Execute takes the result register when writeback holds its source.
        assign stall = 1'b0;
        assign byp_a = fo_vld && ex_vld && ex_rd == fo_rs1;
        assign byp_b = fo_vld && ex_vld && ex_rd == fo_rs2;

        assert_dep_uses_by_R7: assert property (@(posedge clk) disable iff (!rst_n)
            dep |=> (byp_a || byp_b));
    end else begin : g_interlock
        // Hold operand fetch one cycle so the value arrives through the file.
        assign stall = dep;
        assign byp_a = 1'b0;
        assign byp_b = 1'b0;

        assert_no_raw_in_ex_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (fo_vld && ex_vld) |-> (ex_rd != fo_rs1 && ex_rd != fo_rs2));
    end

    assert_stall_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (di_vld && fo_vld));
endmodule

// File: rtl/p5_exec.sv
// Execute datapath: picks each operand from its operand register or from the
// bypass register, then applies the ALU. Purely combinational.
module p5_exec
    import p5_pkg::*;
(
    input  logic              vld,
    input  op_e               op,
    input  logic [RA_W-1:0]   rd,
    input  logic [DATA_W-1:0] s1,
    input  logic [DATA_W-1:0] s2,
    input  logic              byp_a,
    input  logic              byp_b,
    input  logic [DATA_W-1:0] by_data,
    output result_t           res
);
    logic [DATA_W-1:0] opa, opb;

    // Operand select and result formation.
    always_comb begin
        opa      = byp_a ? by_data : s1;
        opb      = byp_b ? by_data : s2;
        res.vld  = vld;
        res.rd   = rd;
        res.data = alu(op, opa, opb);
    end
endmodule

// File: rtl/inorder_pipe5.sv
// Top: five-stage in-order ALU pipeline. Stage registers: fetch (fi_q),
// decode (di_q, the instruction in operand fetch), operand (fo_q with s1/s2,
// the instruction in execute), result (ex_q, the instruction in writeback and
// also the bypass register). Assumes IMEM_DEPTH is a power of two and
// 5 <= NREGS <= 8.
module inorder_pipe5
    import p5_pkg::*;
#(
    parameter int NREGS      = 8,
    parameter int IMEM_DEPTH = 32,
    parameter bit BYPASS_EN  = 1'b1,
    localparam int IA_W = $clog2(IMEM_DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    imem_we,
    input  logic [IA_W-1:0]         imem_addr,
    input  logic [INSTR_W-1:0]      imem_wdata,
    output logic [IA_W-1:0]         dbg_pc,
    output logic                    dbg_stall,
    output logic [INSTR_W-1:0]      dbg_fi_instr,
    output logic [INSTR_W-1:0]      dbg_di_instr,
    output logic [INSTR_W-1:0]      dbg_fo_instr,
    output logic [DATA_W-1:0]       dbg_s1,
    output logic [DATA_W-1:0]       dbg_s2,
    output logic [DATA_W-1:0]       dbg_by,
    output logic                    dbg_wb_en,
    output logic [RA_W-1:0]         dbg_wb_rd,
    output logic [NREGS*DATA_W-1:0] dbg_regs,
    output logic [NREGS-1:0]        dbg_reg_busy
);
    logic [IA_W-1:0]   pc;
    logic              stall, byp_a, byp_b;
    instr_t            fi_q, di_q, fo_q;
    logic [DATA_W-1:0] s1_q, s2_q, rd_a, rd_b;
    result_t           ex_d, ex_q;

    p5_fetch #(.IMEM_DEPTH(IMEM_DEPTH)) u_fetch (
        .clk(clk), .rst_n(rst_n), .stall(stall),
        .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
        .pc(pc), .fi_q(fi_q)
    );

    // Decode register: held during a stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            di_q <= '0;
        end else if (!stall) begin
            di_q <= fi_q;
        end
    end

    p5_regfile #(.NREGS(NREGS)) u_rf (
        .clk(clk), .rst_n(rst_n), .wr(ex_q),
        .addr_a(di_q.rs1), .addr_b(di_q.rs2),
        .rd_a(rd_a), .rd_b(rd_b), .regs_flat(dbg_regs)
    );

    // Operand register: captures S1/S2, or takes an empty slot on a stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fo_q <= '0;
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            fo_q <= stall ? '0 : di_q;
            s1_q <= rd_a;
            s2_q <= rd_b;
        end
    end

    p5_hazard #(.BYPASS_EN(BYPASS_EN)) u_hazard (
        .clk(clk), .rst_n(rst_n),
        .di_vld(di_q.vld), .di_rs1(di_q.rs1), .di_rs2(di_q.rs2),
        .fo_vld(fo_q.vld), .fo_rd(fo_q.rd), .fo_rs1(fo_q.rs1), .fo_rs2(fo_q.rs2),
        .ex_vld(ex_q.vld), .ex_rd(ex_q.rd),
        .stall(stall), .byp_a(byp_a), .byp_b(byp_b)
    );

    p5_exec u_exec (
        .vld(fo_q.vld), .op(fo_q.op), .rd(fo_q.rd),
        .s1(s1_q), .s2(s2_q), .byp_a(byp_a), .byp_b(byp_b),
        .by_data(ex_q.data), .res(ex_d)
    );

    // Result / bypass register feeding writeback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_q <= '0;
        end else begin
            ex_q <= ex_d;
        end
    end

    // Busy flags: a write to the register is in execute or writeback.
    for (genvar r = 0; r < NREGS; r++) begin : g_busy
        assign dbg_reg_busy[r] = (fo_q.vld && fo_q.rd == RA_W'(r)) ||
                                 (ex_q.vld && ex_q.rd == RA_W'(r));
    end

    assign dbg_pc       = pc;
    assign dbg_stall    = stall;
    assign dbg_fi_instr = fi_q;
    assign dbg_di_instr = di_q;
    assign dbg_fo_instr = fo_q;
    assign dbg_s1       = s1_q;
    assign dbg_s2       = s2_q;
    assign dbg_by       = ex_q.data;
    assign dbg_wb_en    = ex_q.vld;
    assign dbg_wb_rd    = ex_q.rd;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (pc == '0 && !fi_q.vld && !di_q.vld && !fo_q.vld && !ex_q.vld));

    assert_stall_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !fo_q.vld);

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(di_q) && $stable(pc)));
endmodule

// File: tb/inorder_pipe5_tb_top.sv
// Scoreboard bench: a driver loads each program, runs a sequential model and
// queues the expected writebacks (destination, value, cycle) for a bypass and
// an interlock build; a monitor pops and compares them as writebacks appear.
module inorder_pipe5_tb_top;
    import p5_pkg::*;

    localparam int NREGS = 8;
    localparam int DEPTH = 32;
    localparam int IA_W  = 5;
    localparam int DW    = 16;

    typedef struct {
        int              cyc;
        int              rd;
        logic [DW-1:0]   data;
    } wb_t;

    logic clk = 1'b0;
    always #2.5ns clk = ~clk;

    logic               rst_n = 1'b0;
    logic               we = 1'b0;
    logic [IA_W-1:0]    waddr = '0;
    logic [INSTR_W-1:0] wdata = '0;

    logic [IA_W-1:0]     pc_b, pc_n;
    logic                stall_b, stall_n, wbv_b, wbv_n;
    logic [INSTR_W-1:0]  fi_b, fi_n, di_b, di_n, fo_b, fo_n;
    logic [DW-1:0]       s1_b, s1_n, s2_b, s2_n, by_b, by_n;
    logic [2:0]          wbrd_b, wbrd_n;
    logic [NREGS*DW-1:0] regs_b, regs_n;
    logic [NREGS-1:0]    busy_b, busy_n;

    inorder_pipe5 #(.NREGS(NREGS), .IMEM_DEPTH(DEPTH), .BYPASS_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .imem_we(we), .imem_addr(waddr), .imem_wdata(wdata),
        .dbg_pc(pc_b), .dbg_stall(stall_b), .dbg_fi_instr(fi_b), .dbg_di_instr(di_b),
        .dbg_fo_instr(fo_b), .dbg_s1(s1_b), .dbg_s2(s2_b), .dbg_by(by_b),
        .dbg_wb_en(wbv_b), .dbg_wb_rd(wbrd_b), .dbg_regs(regs_b), .dbg_reg_busy(busy_b)
    );

    inorder_pipe5 #(.NREGS(NREGS), .IMEM_DEPTH(DEPTH), .BYPASS_EN(1'b0)) dut_nobyp_i (
        .clk(clk), .rst_n(rst_n), .imem_we(we), .imem_addr(waddr), .imem_wdata(wdata),
        .dbg_pc(pc_n), .dbg_stall(stall_n), .dbg_fi_instr(fi_n), .dbg_di_instr(di_n),
        .dbg_fo_instr(fo_n), .dbg_s1(s1_n), .dbg_s2(s2_n), .dbg_by(by_n),
        .dbg_wb_en(wbv_n), .dbg_wb_rd(wbrd_n), .dbg_regs(regs_n), .dbg_reg_busy(busy_n)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int pid    = 0;
    int plen   = 0;
    int st_cnt_b = 0, st_cnt_n = 0, exp_st_n = 0;
    bit mon_en = 1'b0;
    string cur_tag = "";
    logic [INSTR_W-1:0] prog [DEPTH];
    logic [DW-1:0] mreg [NREGS];
    wb_t q_b[$];
    wb_t q_n[$];

    task automatic check(input bit ok, input string msg, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", msg, act, exp);
        end
    endtask

    function automatic logic [INSTR_W-1:0] enc(input logic [1:0] op, input int rd,
                                               input int a, input int b);
        return {1'b1, op, rd[2:0], a[2:0], b[2:0]};
    endfunction

    function automatic logic [DW-1:0] model_alu(input logic [1:0] op,
                                                input logic [DW-1:0] a,
                                                input logic [DW-1:0] b);
        case (op)
            2'd0:    return a + b;
            2'd1:    return a - b;
            2'd2:    return a & b;
            default: return a ^ b;
        endcase
    endfunction

    function automatic logic [DW-1:0] init_val(input int i);
        return DW'((i + 1) * 32'h1111);
    endfunction

    // Edge counter since reset release.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic wb_check(input string who, input bit have, input wb_t e,
                            input logic [2:0] rd, input logic [DW-1:0] d,
                            input string ttag);
        check(have, {"R2 ", cur_tag, " ", who, " unexpected writeback"}, 32'(have), 32'd1);
        if (have) begin
            check(rd == e.rd[2:0], {"R2 ", cur_tag, " ", who, " writeback rd"}, 32'(rd), 32'(e.rd));
            check(d == e.data, {"R2 ", cur_tag, " ", who, " writeback value"}, 32'(d), 32'(e.data));
            check(cyc == e.cyc, {ttag, " ", cur_tag, " ", who, " writeback cycle"}, 32'(cyc), 32'(e.cyc));
        end
    endtask

    // Monitor: pop the scoreboard on each writeback, count stall cycles.
    always @(negedge clk) begin
        wb_t e;
        bit  have;
        if (mon_en && rst_n) begin
            if (stall_b) st_cnt_b++;
            if (stall_n) st_cnt_n++;
            if (wbv_b) begin
                have = (q_b.size() != 0);
                if (have) e = q_b.pop_front();
                wb_check("bypass", have, e, wbrd_b, by_b, "R3 R7");
            end
            if (wbv_n) begin
                have = (q_n.size() != 0);
                if (have) e = q_n.pop_front();
                wb_check("interlock", have, e, wbrd_n, by_n, "R3 R6");
            end
        end
    end

    // Cycle-specific probes for directed programs.
    task automatic probe();
        if (pid == 1 && cyc == 3) begin
            check(fo_b == prog[0], "R4 instruction in execute", 32'(fo_b), 32'(prog[0]));
            check(s1_b == init_val(0), "R4 S1 holds first source", 32'(s1_b), 32'(init_val(0)));
            check(s2_b == init_val(1), "R4 S2 holds second source", 32'(s2_b), 32'(init_val(1)));
            check(busy_b == 8'b0000_1000, "R8 busy with one write in execute", 32'(busy_b), 32'h08);
        end
        if (pid == 1 && cyc == 4) begin
            check(busy_b == 8'b0001_1000, "R8 busy with writes in execute and writeback",
                  32'(busy_b), 32'h18);
        end
        if (pid == 2 && cyc == 3) begin
            check(stall_n == 1'b1, "R6 interlock stalls on adjacent dependency", 32'(stall_n), 32'd1);
            check(stall_b == 1'b0, "R7 bypass build does not stall", 32'(stall_b), 32'd0);
        end
        if (pid == 2 && cyc == 4) begin
            check(pc_n == 5'd3, "R6 PC held during stall", 32'(pc_n), 32'd3);
            check(fo_n[INSTR_W-1] == 1'b0, "R6 empty slot enters execute", 32'(fo_n), 32'd0);
            check(di_n == prog[1], "R6 dependent held in operand fetch", 32'(di_n), 32'(prog[1]));
            check(pc_b == 5'd4, "R7 PC advances with bypass", 32'(pc_b), 32'd4);
            check(fo_b == prog[1], "R7 dependent enters execute", 32'(fo_b), 32'(prog[1]));
        end
        if (pid == 3 && cyc == 5) begin
            check(wbv_b == 1'b0, "R10 invalid word writes nothing (bypass)", 32'(wbv_b), 32'd0);
            check(wbv_n == 1'b0, "R10 invalid word writes nothing (interlock)", 32'(wbv_n), 32'd0);
        end
    endtask

    task automatic check_reset_state();
        check(pc_b == '0 && pc_n == '0, "R1 PC cleared", 32'({pc_b, pc_n}), 32'd0);
        check(!fi_b[11] && !di_b[11] && !fo_b[11] && !fi_n[11] && !di_n[11] && !fo_n[11],
              "R1 stages empty", 32'({fi_b[11], di_b[11], fo_b[11], fi_n[11], di_n[11], fo_n[11]}), 32'd0);
        check(!wbv_b && !wbv_n, "R1 no writeback", 32'({wbv_b, wbv_n}), 32'd0);
        check(busy_b == '0 && busy_n == '0, "R1 busy flags clear", 32'({busy_b, busy_n}), 32'd0);
        for (int i = 0; i < NREGS; i++) begin
            check(regs_b[i*DW +: DW] == init_val(i) && regs_n[i*DW +: DW] == init_val(i),
                  "R1 register reset value", 32'(regs_n[i*DW +: DW]), 32'(init_val(i)));
        end
    endtask

    // Driver: load, model, run, then compare the final register image.
    task automatic run_prog(input string tag);
        int t;
        bit prev_v;
        logic [2:0] prev_rd;
        int stalls;
        cur_tag = tag;
        @(negedge clk);
        rst_n = 1'b0;
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            we    = 1'b1;
            waddr = IA_W'(a);
            wdata = (a < plen) ? prog[a] : '0;
        end
        @(negedge clk);
        we = 1'b0;
        @(negedge clk);
        check_reset_state();

        for (int i = 0; i < NREGS; i++) mreg[i] = init_val(i);
        prev_v = 1'b0;
        prev_rd = '0;
        stalls = 0;
        for (int a = 0; a < plen; a++) begin
            logic [INSTR_W-1:0] p;
            logic [DW-1:0] r;
            p = prog[a];
            if (p[11]) begin
                if (prev_v && (prev_rd == p[5:3] || prev_rd == p[2:0])) stalls++;
                r = model_alu(p[10:9], mreg[p[5:3]], mreg[p[2:0]]);
                q_b.push_back('{cyc: 4 + a, rd: int'(p[8:6]), data: r});
                q_n.push_back('{cyc: 4 + a + stalls, rd: int'(p[8:6]), data: r});
                mreg[p[8:6]] = r;
                prev_v = 1'b1;
                prev_rd = p[8:6];
            end else begin
                prev_v = 1'b0;
            end
        end
        exp_st_n = stalls;
        st_cnt_b = 0;
        st_cnt_n = 0;
        mon_en = 1'b1;
        rst_n = 1'b1;
        t = 0;
        while ((q_b.size() != 0 || q_n.size() != 0) && t < 200) begin
            @(negedge clk);
            t++;
            probe();
        end
        check(t < 200, {"R3 ", tag, " all writebacks seen"}, 32'(t), 32'd200);
        repeat (2) @(negedge clk);
        mon_en = 1'b0;
        check(st_cnt_n == exp_st_n, {"R6 ", tag, " interlock stall cycles"}, 32'(st_cnt_n), 32'(exp_st_n));
        check(st_cnt_b == 0, {"R7 ", tag, " bypass stall cycles"}, 32'(st_cnt_b), 32'd0);
        check(busy_b == '0 && busy_n == '0, {"R8 ", tag, " busy clear when drained"},
              32'({busy_b, busy_n}), 32'd0);
        for (int i = 0; i < NREGS; i++) begin
            check(regs_b[i*DW +: DW] == mreg[i], {"R9 ", tag, " final register (bypass)"},
                  32'(regs_b[i*DW +: DW]), 32'(mreg[i]));
            check(regs_n[i*DW +: DW] == mreg[i], {"R9 ", tag, " final register (interlock)"},
                  32'(regs_n[i*DW +: DW]), 32'(mreg[i]));
        end
        q_b.delete();
        q_n.delete();
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R3: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // P1: independent instructions, all four operations.
        pid = 1; plen = 4;
        prog[0] = enc(2'd0, 3, 0, 1);
        prog[1] = enc(2'd1, 4, 7, 2);
        prog[2] = enc(2'd2, 5, 6, 1);
        prog[3] = enc(2'd3, 6, 2, 7);
        run_prog("P1 R2 R4 R8");

        // P2: chain of adjacent dependencies.
        pid = 2; plen = 4;
        prog[0] = enc(2'd1, 1, 2, 3);
        prog[1] = enc(2'd0, 2, 1, 1);
        prog[2] = enc(2'd3, 4, 2, 0);
        prog[3] = enc(2'd2, 5, 4, 2);
        run_prog("P2 R6 R7");

        // P3: empty slot, distance-two reads through the register file.
        pid = 3; plen = 6;
        prog[0] = enc(2'd0, 1, 0, 0);
        prog[1] = '0;
        prog[2] = enc(2'd1, 2, 1, 0);
        prog[3] = enc(2'd0, 3, 2, 2);
        prog[4] = enc(2'd3, 4, 7, 6);
        prog[5] = enc(2'd2, 6, 3, 3);
        run_prog("P3 R5 R10");

        // P4: write-after-write then a reader of the younger value.
        pid = 4; plen = 4;
        prog[0] = enc(2'd0, 1, 2, 3);
        prog[1] = enc(2'd3, 1, 4, 5);
        prog[2] = enc(2'd0, 7, 1, 1);
        prog[3] = enc(2'd1, 0, 1, 7);
        run_prog("P4 R9");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule